// File: doc/BRIEF.md
# SCSI Target Information-Transfer Phase Sequencer

This block is the target-side engine that runs the information-transfer phases of a SCSI peripheral once it has been selected. A command executor asks for a phase (send data, receive data, send status, or send a message) together with a byte count. The sequencer drives the three phase lines, then moves bytes one at a time with a REQ/ACK handshake. Outgoing bytes come from a local byte buffer and incoming bytes are written into it, through a pointer that restarts at zero with every phase. When the pointer reaches the count, a one-cycle completion pulse goes back to the executor.

A request can carry a follow-on phase, for example status after data. The sequencer starts that phase by itself as soon as the current one completes. A completed message phase ends the connection: BSY and every other line are released and the bus goes free.

While a phase is active, the sequencer compares the phase lines it samples from the bus with the lines it drives. Any difference aborts the connection: every line is released, a pending follow-on phase is discarded, and the block waits for a new selection. The executor loads and reads the buffer through its own port.

Top module: `scsi_tgt_phase_seq`

## Requirements
- R1: After reset and whenever the bus is free, BSY, REQ, the three phase lines and the data-bus drive enable are all low. A pulse on `sel_i` while free asserts BSY on the next cycle with the phase lines still low (connected, idle).
- R2: While a phase is active, {msg_o, cd_o, io_o} carries the code of the requested operation: op 0 (send data) gives 001, op 1 (receive data) gives 000, op 2 (status) gives 011, op 3 (message) gives 111.
- R3: Each byte uses a full handshake. REQ rises and stays high until ACK is seen high. REQ then falls, and it does not rise again while ACK is still high.
- R4: For ops 0, 2 and 3, `db_oe_o` is high while REQ is up, and `db_o` carries buffer bytes in order starting at address 0.
- R5: For op 1, `db_oe_o` stays low, and the byte on `db_i` when ACK is first seen high is written to the buffer at the pointer, starting at address 0.
- R6: `done_o` is high for exactly one cycle, with `done_op_o` equal to the finished op, in the cycle after ACK falls on the last byte. A length of 0 completes in the cycle after the request without raising REQ.
- R7: If `nxt_valid_i` was high with a request, the follow-on op and length start on the cycle after `done_o`, with the pointer back at 0. Without one, the block returns to connected-idle with BSY held.
- R8: In the cycle after a message phase completes, BSY and all lines are released and any follow-on request is discarded.
- R9: If the sampled phase lines differ from the driven ones while a phase is active, the next cycle shows the bus free with `abort_o` high for one cycle, and no follow-on phase starts.
- R10: Phase lines are not compared while connected and idle; a difference there causes no abort.
- R11: `cmd_valid_i` has no effect unless the block is connected and idle.
- R12: The executor port writes a buffer byte on `buf_we_i`, and `buf_rdata_o` shows the byte at `buf_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Selection of this target detected |
| ack_i | input | 1 | ACK from the initiator |
| bus_msg_i | input | 1 | Sampled MSG line |
| bus_cd_i | input | 1 | Sampled C/D line |
| bus_io_i | input | 1 | Sampled I/O line |
| db_i | input | DATA_W | Sampled data bus |
| bsy_o | output | 1 | BSY drive |
| req_o | output | 1 | REQ drive |
| msg_o | output | 1 | MSG drive |
| cd_o | output | 1 | C/D drive |
| io_o | output | 1 | I/O drive |
| db_o | output | DATA_W | Data bus value |
| db_oe_o | output | 1 | Data bus drive enable |
| cmd_valid_i | input | 1 | Phase request from the executor |
| cmd_op_i | input | 2 | Requested op (0 send data, 1 receive data, 2 status, 3 message) |
| cmd_len_i | input | LEN_W | Byte count of the request |
| nxt_valid_i | input | 1 | Request carries a follow-on phase |
| nxt_op_i | input | 2 | Follow-on op |
| nxt_len_i | input | LEN_W | Follow-on byte count |
| done_o | output | 1 | Phase complete pulse |
| done_op_o | output | 2 | Op that completed |
| abort_o | output | 1 | Phase mismatch abort pulse |
| buf_we_i | input | 1 | Executor buffer write strobe |
| buf_addr_i | input | ADDR_W | Executor buffer address |
| buf_wdata_i | input | DATA_W | Executor buffer write data |
| buf_rdata_o | output | DATA_W | Executor buffer read data |

## Verification
Two pairs of events can land on the same clock edge. The first is the completion of one phase and the start of its follow-on phase. The bench issues chained requests of every data op followed by status or message, and checks that `done_o` is seen exactly once before the new phase lines and REQ appear, with the pointer back at address 0. The second is a phase-line mismatch that arrives while a follow-on request is still pending. The bench forces a line difference during a chained data phase and requires a free bus with `abort_o`, with no REQ and no follow-on phase in the cycles after it.

// File: rtl/scsi_tgt_pkg.sv
package scsi_tgt_pkg;

   typedef enum logic [1:0] {
      OP_SEND_DATA = 2'd0,
      OP_RECV_DATA = 2'd1,
      OP_STATUS    = 2'd2,
      OP_MESSAGE   = 2'd3
   } scsi_op_e;

   typedef enum logic [2:0] {
      ST_FREE  = 3'd0,
      ST_CONN  = 3'd1,
      ST_REQ   = 3'd2,
      ST_ACKW  = 3'd3,
      ST_FIN   = 3'd4
   } seq_state_e;

   typedef struct packed {
      logic msg;
      logic cd;
      logic io;
   } phase_lines_t;

endpackage

// File: rtl/scsi_tgt_phase_map.sv
module scsi_tgt_phase_map
   import scsi_tgt_pkg::*;
(
   input  scsi_op_e     op_i,
   output phase_lines_t lines_o,
   output logic         dir_in_o
);

   always_comb begin
      unique case (op_i)
         OP_SEND_DATA: lines_o = '{msg: 1'b0, cd: 1'b0, io: 1'b1};
         OP_RECV_DATA: lines_o = '{msg: 1'b0, cd: 1'b0, io: 1'b0};
         OP_STATUS:    lines_o = '{msg: 1'b0, cd: 1'b1, io: 1'b1};
         default:      lines_o = '{msg: 1'b1, cd: 1'b1, io: 1'b1};
      endcase
   end

   // Bytes travel toward the initiator whenever I/O is asserted.
   assign dir_in_o = lines_o.io;

endmodule

// File: rtl/scsi_tgt_buf.sv
module scsi_tgt_buf #(
   parameter int DATA_W         = 8,
   parameter int DEPTH          = 16,
   parameter int ADDR_W         = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);

   logic [DATA_W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      logic              hit_a;
      logic              hit_b;

      assign hit_a = a_we && (a_addr == ADDR_W'(i));
      assign hit_b = b_we && (b_addr == ADDR_W'(i));

      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     word_q <= '0;
            else if (hit_b) word_q <= b_wdata;
            else if (hit_a) word_q <= a_wdata;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit_b)      word_q <= b_wdata;
            else if (hit_a) word_q <= a_wdata;
         end
      end

      assign words[i] = word_q;
   end

   assign a_rdata = words[a_addr];
   assign b_rdata = words[b_addr];

endmodule

// File: rtl/scsi_tgt_byte_ptr.sv
module scsi_tgt_byte_ptr #(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [LEN_W-1:0] ptr_o,
   output logic             last_o
);

   logic [LEN_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_q <= '0;
      else if (clr_i) ptr_q <= '0;
      else if (inc_i) ptr_q <= ptr_q + LEN_W'(1);
   end

   assign ptr_o  = ptr_q;
   assign last_o = (ptr_q + LEN_W'(1)) == len_i;

endmodule

// File: rtl/scsi_tgt_phase_seq.sv
module scsi_tgt_phase_seq
   import scsi_tgt_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int DEPTH          = 16,
   parameter int ADDR_W         = $clog2(DEPTH),
   parameter int LEN_W          = $clog2(DEPTH + 1),
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              ack_i,
   input  logic              bus_msg_i,
   input  logic              bus_cd_i,
   input  logic              bus_io_i,
   input  logic [DATA_W-1:0] db_i,
   output logic              bsy_o,
   output logic              req_o,
   output logic              msg_o,
   output logic              cd_o,
   output logic              io_o,
   output logic [DATA_W-1:0] db_o,
   output logic              db_oe_o,
   input  logic              cmd_valid_i,
   input  logic [1:0]        cmd_op_i,
   input  logic [LEN_W-1:0]  cmd_len_i,
   input  logic              nxt_valid_i,
   input  logic [1:0]        nxt_op_i,
   input  logic [LEN_W-1:0]  nxt_len_i,
   output logic              done_o,
   output logic [1:0]        done_op_o,
   output logic              abort_o,
   input  logic              buf_we_i,
   input  logic [ADDR_W-1:0] buf_addr_i,
   input  logic [DATA_W-1:0] buf_wdata_i,
   output logic [DATA_W-1:0] buf_rdata_o
);

   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert ((1 << ADDR_W) == DEPTH) else $error("DEPTH must be a power of two matching ADDR_W");
      assert (LEN_W == $clog2(DEPTH + 1)) else $error("LEN_W must hold DEPTH");
   end

   // ---------------------------------------------------------------
   // State
   // ---------------------------------------------------------------
   seq_state_e       st_q, st_d;
   scsi_op_e         op_q;
   logic [LEN_W-1:0] len_q;
   logic             nv_q;
   scsi_op_e         nop_q;
   logic [LEN_W-1:0] nlen_q;
   logic             abort_q;

   logic             load_cmd, load_nxt, clr_nxt;
   logic             ptr_clr, ptr_inc, seq_we;
   logic [LEN_W-1:0] ptr;
   logic             ptr_last;

   phase_lines_t     lines;
   logic             dir_in;
   logic             phase_act;
   logic             xfer_act;
   logic             mismatch;
   logic [DATA_W-1:0] seq_rdata;

   // ---------------------------------------------------------------
   // Sub-blocks
   // ---------------------------------------------------------------
   scsi_tgt_phase_map u_map (
      .op_i     (op_q),
      .lines_o  (lines),
      .dir_in_o (dir_in)
   );

   scsi_tgt_byte_ptr #(.LEN_W(LEN_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (ptr_clr),
      .inc_i  (ptr_inc),
      .len_i  (len_q),
      .ptr_o  (ptr),
      .last_o (ptr_last)
   );

   scsi_tgt_buf #(
      .DATA_W         (DATA_W),
      .DEPTH          (DEPTH),
      .ADDR_W         (ADDR_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_we    (buf_we_i),
      .a_addr  (buf_addr_i),
      .a_wdata (buf_wdata_i),
      .a_rdata (buf_rdata_o),
      .b_we    (seq_we),
      .b_addr  (ptr[ADDR_W-1:0]),
      .b_wdata (db_i),
      .b_rdata (seq_rdata)
   );

   // ---------------------------------------------------------------
   // Phase watch
   // ---------------------------------------------------------------
   assign phase_act = (st_q == ST_REQ) || (st_q == ST_ACKW) || (st_q == ST_FIN);
   assign xfer_act  = (st_q == ST_REQ) || (st_q == ST_ACKW);
   assign mismatch  = phase_act &&
                      ({bus_msg_i, bus_cd_i, bus_io_i} != {lines.msg, lines.cd, lines.io});

   // ---------------------------------------------------------------
   // Next state
   // ---------------------------------------------------------------
   always_comb begin
      st_d     = st_q;
      load_cmd = 1'b0;
      load_nxt = 1'b0;
      clr_nxt  = 1'b0;
      ptr_clr  = 1'b0;
      ptr_inc  = 1'b0;
      seq_we   = 1'b0;

      unique case (st_q)
         ST_FREE: begin
            if (sel_i) st_d = ST_CONN;
         end
         ST_CONN: begin
            if (cmd_valid_i) begin
               load_cmd = 1'b1;
               ptr_clr  = 1'b1;
               st_d     = (cmd_len_i == '0) ? ST_FIN : ST_REQ;
            end
         end
         ST_REQ: begin
            if (ack_i) begin
               seq_we = !dir_in;
               st_d   = ST_ACKW;
            end
         end
         ST_ACKW: begin
            if (!ack_i) begin
               ptr_inc = 1'b1;
               st_d    = ptr_last ? ST_FIN : ST_REQ;
            end
         end
         ST_FIN: begin
            if (op_q == OP_MESSAGE) begin
               clr_nxt = 1'b1;
               st_d    = ST_FREE;
            end else if (nv_q) begin
               load_nxt = 1'b1;
               ptr_clr  = 1'b1;
               st_d     = (nlen_q == '0) ? ST_FIN : ST_REQ;
            end else begin
               st_d = ST_CONN;
            end
         end
         default: st_d = ST_FREE;
      endcase

      if (mismatch) begin
         st_d     = ST_FREE;
         load_nxt = 1'b0;
         clr_nxt  = 1'b1;
         ptr_clr  = 1'b0;
         ptr_inc  = 1'b0;
         seq_we   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_FREE;
         op_q    <= OP_RECV_DATA;
         len_q   <= '0;
         nv_q    <= 1'b0;
         nop_q   <= OP_RECV_DATA;
         nlen_q  <= '0;
         abort_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         abort_q <= mismatch;
         if (load_cmd) begin
            op_q   <= scsi_op_e'(cmd_op_i);
            len_q  <= cmd_len_i;
            nv_q   <= nxt_valid_i;
            nop_q  <= scsi_op_e'(nxt_op_i);
            nlen_q <= nxt_len_i;
         end else if (load_nxt) begin
            op_q  <= nop_q;
            len_q <= nlen_q;
            nv_q  <= 1'b0;
         end else if (clr_nxt) begin
            nv_q <= 1'b0;
         end
      end
   end

   // ---------------------------------------------------------------
   // Outputs
   // ---------------------------------------------------------------
   assign bsy_o     = (st_q != ST_FREE);
   assign req_o     = (st_q == ST_REQ);
   assign msg_o     = phase_act & lines.msg;
   assign cd_o      = phase_act & lines.cd;
   assign io_o      = phase_act & lines.io;
   assign db_oe_o   = xfer_act & dir_in;
   assign db_o      = db_oe_o ? seq_rdata : '0;
   assign done_o    = (st_q == ST_FIN);
   assign done_op_o = op_q;
   assign abort_o   = abort_q;

endmodule

// File: rtl/scsi_tgt_phase_seq_chk.sv
module scsi_tgt_phase_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bsy_o,
   input logic       req_o,
   input logic       msg_o,
   input logic       cd_o,
   input logic       io_o,
   input logic       db_oe_o,
   input logic       ack_i,
   input logic       bus_msg_i,
   input logic       bus_cd_i,
   input logic       bus_io_i,
   input logic       done_o,
   input logic [1:0] done_op_o,
   input logic       abort_o,
   input logic       phase_act
);

   logic mism;
   assign mism = phase_act && ({bus_msg_i, bus_cd_i, bus_io_i} != {msg_o, cd_o, io_o});

   // R1: a free bus drives nothing
   a_r1_free_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bsy_o |-> !(req_o || msg_o || cd_o || io_o || db_oe_o));

   // R3: REQ is held until ACK arrives
   a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i && !mism) |=> req_o);

   // R3: no new REQ while ACK is still high
   a_r3_no_req_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (bsy_o && !req_o && ack_i && !mism) |=> !req_o);

   // R4: data bus is driven exactly in the in-direction
   a_r4_drive_dir: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (db_oe_o == io_o));

   // R8: a finished message phase frees the bus
   a_r8_msg_release: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && done_op_o == 2'd3 && !mism) |=> !bsy_o);

   // R9: a phase mismatch aborts to bus free
   a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
      mism |=> (!bsy_o && abort_o));

   // R10: idle connection never aborts
   a_r10_idle_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (bsy_o && !phase_act) |=> !abort_o);

endmodule

bind scsi_tgt_phase_seq scsi_tgt_phase_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bsy_o     (bsy_o),
   .req_o     (req_o),
   .msg_o     (msg_o),
   .cd_o      (cd_o),
   .io_o      (io_o),
   .db_oe_o   (db_oe_o),
   .ack_i     (ack_i),
   .bus_msg_i (bus_msg_i),
   .bus_cd_i  (bus_cd_i),
   .bus_io_i  (bus_io_i),
   .done_o    (done_o),
   .done_op_o (done_op_o),
   .abort_o   (abort_o),
   .phase_act (phase_act)
);

// File: tb/tb_scsi_tgt_phase_seq.sv
`timescale 1ns/1ps
module tb_scsi_tgt_phase_seq;

   localparam int DW    = 8;
   localparam int DEPTH = 16;
   localparam int AW    = 4;
   localparam int LW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0, ack = 1'b0;
   logic [2:0]    mis = 3'b000;
   logic [DW-1:0] db_i = '0;
   logic          bsy_o, req_o, msg_o, cd_o, io_o, db_oe_o, done_o, abort_o;
   logic [DW-1:0] db_o, buf_rdata;
   logic [1:0]    done_op_o;
   logic          cmd_valid = 1'b0, nxt_valid = 1'b0, buf_we = 1'b0;
   logic [1:0]    cmd_op = '0, nxt_op = '0;
   logic [LW-1:0] cmd_len = '0, nxt_len = '0;
   logic [AW-1:0] buf_addr = '0;
   logic [DW-1:0] buf_wdata = '0;
   logic          bus_msg, bus_cd, bus_io;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [DW-1:0] mdl [DEPTH];

   always #10 clk = ~clk;

   assign bus_msg = msg_o ^ mis[2];
   assign bus_cd  = cd_o  ^ mis[1];
   assign bus_io  = io_o  ^ mis[0];

   scsi_tgt_phase_seq #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .ack_i(ack),
      .bus_msg_i(bus_msg), .bus_cd_i(bus_cd), .bus_io_i(bus_io), .db_i(db_i),
      .bsy_o(bsy_o), .req_o(req_o), .msg_o(msg_o), .cd_o(cd_o), .io_o(io_o),
      .db_o(db_o), .db_oe_o(db_oe_o),
      .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_len_i(cmd_len),
      .nxt_valid_i(nxt_valid), .nxt_op_i(nxt_op), .nxt_len_i(nxt_len),
      .done_o(done_o), .done_op_o(done_op_o), .abort_o(abort_o),
      .buf_we_i(buf_we), .buf_addr_i(buf_addr), .buf_wdata_i(buf_wdata),
      .buf_rdata_o(buf_rdata)
   );

   function automatic int exp_lines(input int op);
      case (op)
         0:       return 3'b001;
         1:       return 3'b000;
         2:       return 3'b011;
         default: return 3'b111;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic wait_req();
      int n = 0;
      while (!req_o && n < 40) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic select_tgt();
      sel = 1'b1;
      @(negedge clk);
      sel = 1'b0;
      chk("R1 BSY after selection", int'(bsy_o), 1);
      chk("R1 phase lines idle", int'({msg_o, cd_o, io_o}), 0);
   endtask

   task automatic load_buf(input int a, input int d);
      buf_we = 1'b1; buf_addr = AW'(a); buf_wdata = DW'(d);
      mdl[a] = DW'(d);
      @(negedge clk);
      buf_we = 1'b0;
   endtask

   task automatic issue(input int op, input int len, input bit nv, input int nop, input int nlen);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_len = LW'(len);
      nxt_valid = nv; nxt_op = 2'(nop); nxt_len = LW'(nlen);
      @(negedge clk);
      cmd_valid = 1'b0; nxt_valid = 1'b0;
   endtask

   task automatic run_phase(input int op, input int len);
      for (int i = 0; i < len; i++) begin
         wait_req();
         chk("R2 phase lines", int'({msg_o, cd_o, io_o}), exp_lines(op));
         if (op != 1) begin
            chk("R4 data drive enable", int'(db_oe_o), 1);
            chk("R4 data byte", int'(db_o), int'(mdl[i]));
         end else begin
            logic [DW-1:0] d;
            d = DW'($urandom);
            chk("R5 data bus released", int'(db_oe_o), 0);
            db_i = d;
            mdl[i] = d;
         end
         ack = 1'b1;
         @(negedge clk);
         chk("R3 REQ falls after ACK", int'(req_o), 0);
         ack = 1'b0;
         @(negedge clk);
         if (i == len - 1) begin
            chk("R6 done pulse", int'(done_o), 1);
            chk("R6 done op", int'(done_op_o), op);
         end else begin
            chk("R3 REQ again after ACK fell", int'(req_o), 1);
         end
      end
   endtask

   task automatic verify_buf(input int len);
      for (int j = 0; j < len; j++) begin
         buf_addr = AW'(j);
         #1;
         chk("R5 received byte stored", int'(buf_rdata), int'(mdl[j]));
      end
   endtask

   task automatic after_phase(input int last_op);
      @(negedge clk);
      if (last_op == 3) begin
         chk("R8 bus free after message", int'(bsy_o), 0);
         chk("R6 done single cycle", int'(done_o), 0);
         select_tgt();
      end else begin
         chk("R7 back to connected BSY", int'(bsy_o), 1);
         chk("R6 done single cycle", int'(done_o), 0);
         chk("R7 idle lines", int'({req_o, msg_o, cd_o, io_o}), 0);
      end
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            summary();
         end
      end
   end

   initial begin
      void'($urandom(32'h5C51));
      for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R1 reset BSY", int'(bsy_o), 0);
      chk("R1 reset lines", int'({req_o, msg_o, cd_o, io_o, db_oe_o}), 0);

      // request while free is ignored
      issue(0, 3, 1'b0, 0, 0);
      @(negedge clk);
      chk("R11 request ignored while free", int'({bsy_o, req_o, io_o}), 0);

      select_tgt();

      // mismatch while idle is not an abort
      mis = 3'b101;
      repeat (3) @(negedge clk);
      chk("R10 no abort while idle", int'(abort_o), 0);
      chk("R10 still connected", int'(bsy_o), 1);
      mis = 3'b000;

      // buffer port
      load_buf(5, 8'hA7);
      buf_addr = AW'(5);
      #1;
      chk("R12 buffer port readback", int'(buf_rdata), 8'hA7);
      @(negedge clk);

      // send data chained with status
      for (int k = 0; k < 3; k++) load_buf(k, 8'h30 + k);
      issue(0, 3, 1'b1, 2, 1);
      run_phase(0, 3);
      run_phase(2, 1);
      after_phase(2);

      // receive data
      issue(1, 4, 1'b0, 0, 0);
      run_phase(1, 4);
      after_phase(1);
      verify_buf(4);
      @(negedge clk);

      // zero length completes at once
      issue(2, 0, 1'b0, 0, 0);
      chk("R6 zero-length done", int'(done_o), 1);
      chk("R6 zero-length no REQ", int'(req_o), 0);
      after_phase(2);

      // request during a phase is ignored
      issue(1, 2, 1'b0, 0, 0);
      cmd_valid = 1'b1; cmd_op = 2'd3; cmd_len = LW'(5);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R11 request ignored mid-phase", int'({msg_o, cd_o, io_o}), 0);
      chk("R11 REQ still up", int'(req_o), 1);
      run_phase(1, 2);
      after_phase(1);
      verify_buf(2);
      @(negedge clk);

      // abort on mismatch with a chained phase pending
      for (int k = 0; k < 4; k++) load_buf(k, 8'h51 + k);
      issue(0, 4, 1'b1, 2, 1);
      chk("R2 send data lines", int'({msg_o, cd_o, io_o}), 3'b001);
      mis = 3'b100;
      @(negedge clk);
      mis = 3'b000;
      chk("R9 abort frees BSY", int'(bsy_o), 0);
      chk("R9 abort pulse", int'(abort_o), 1);
      chk("R9 abort REQ low", int'(req_o), 0);
      @(negedge clk);
      chk("R9 abort pulse single", int'(abort_o), 0);
      @(negedge clk);
      chk("R9 follow-on dropped", int'({bsy_o, req_o, cd_o, io_o}), 0);
      select_tgt();

      // message with a follow-on: bus free anyway
      load_buf(0, 8'h00);
      issue(3, 1, 1'b1, 0, 2);
      run_phase(3, 1);
      @(negedge clk);
      chk("R8 message frees bus", int'(bsy_o), 0);
      @(negedge clk);
      chk("R8 follow-on discarded", int'({bsy_o, req_o, io_o}), 0);
      select_tgt();

      // constrained random phases
      for (int it = 0; it < 40; it++) begin
         int op, len, ch, last_op;
         op  = $urandom_range(0, 2);
         len = $urandom_range(1, DEPTH);
         ch  = $urandom_range(0, 2);
         if (op != 1)
            for (int k = 0; k < len; k++) load_buf(k, $urandom_range(0, 255));
         issue(op, len, ch != 0, (ch == 1) ? 2 : 3, 1);
         run_phase(op, len);
         last_op = op;
         if (ch != 0) begin
            last_op = (ch == 1) ? 2 : 3;
            run_phase(last_op, 1);
         end
         after_phase(last_op);
         if (op == 1) begin
            verify_buf(len);
            @(negedge clk);
         end
      end

      summary();
   end

endmodule